// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single requests from an on-chip master into external memory cycles on a 16-bit bus that carries the address and the data on the same lines. Every cycle opens with an address state and then moves to a strobe state. During the address state the address is driven and an address strobe marks it for external latching. During the strobe state a read strobe or write strobes are active and the data is exchanged. Wait states lengthen the strobe state. Some are forced by a configured internal count. Others come from a ready input that the external memory pulls low.

The width of each cycle is chosen while the cycle runs. When dynamic width is enabled, a width input is sampled in the address state and picks 16-bit or 8-bit. When it is disabled, every cycle is 8-bit. A two-byte request on an 8-bit cycle is performed as two back-to-back byte cycles. Configuration selects the write strobe style and the address strobe style. The write strobes either act as a single write plus a high-byte enable, or as separate low-byte and high-byte write strobes. The address strobe either gives a short latch pulse or acts as an address-valid level. The master holds `reqValid` with stable fields until it sees the one-clock `ack`, and drops it in that same clock. Configuration inputs change only while the bus is idle.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset the controller is idle: `rdN`, `wrLoN` and `wrHiN` are 1, `ack`, `instOut` and `adOe` are 0, and `aleOut` is 0 in pulse mode.
- R2: `busClk` toggles on every rising edge of `clk` (half the clock rate, 50% duty). One bus state is two `clk` periods.
- R3: A cycle with no wait state lasts four `clk` periods. The address state is two periods, and in pulse mode (`cfgAdvMode`=0) `aleOut` is high only in its first period. The strobe state is two periods with the active strobe low for both.
- R4: With `cfgDynWidth`=0 every cycle is 8-bit. With `cfgDynWidth`=1, `busWidthIn` sampled in the address state selects a 16-bit cycle (1) or an 8-bit cycle (0). An 8-bit cycle puts write data on `adOut[7:0]` and takes read data from `adIn[7:0]`. A 16-bit cycle uses all 16 lines, with the byte of odd address on bits 15:8.
- R5: The address driven in the address state is `{reqAddr, odd}`, where odd is 1 only for the second byte of a split transfer or when `reqByteEn`=2'b10 (bit 0 enables the even byte, bit 1 the odd byte; 2'b00 is not allowed). When `reqByteEn`=2'b11 meets an 8-bit cycle, the transfer becomes two byte cycles, even address first and then odd, with no idle state between them.
- R6: `cfgWaitStates`=N inserts N wait states of two `clk` periods each after the strobe state, whatever `readyIn` shows.
- R7: `readyIn` is sampled in the first period of each strobe or wait state once the internal count is used up. A low sample adds another wait state, and the cycle ends after the first high sample. With K low samples the strobe stays low for 2*(1+max(N,K)) periods.
- R8: With `cfgSplitWr`=1, `wrLoN` is low only while the even byte is written, and `wrHiN` only while the odd byte is written. A read never drives a write strobe.
- R9: With `cfgSplitWr`=0, `wrLoN` is low on every write. `wrHiN` acts as a high-byte enable and is low only while a 16-bit cycle writes the odd byte.
- R10: With `cfgAdvMode`=1, `aleOut` is low from the second period of the address state to the end of the cycle. It is high in the first period of each address state and while idle.
- R11: `instOut` is high during every period of each cycle of a fetch read (`reqFetch`=1). It is low for data reads, for writes and while idle.
- R12: `adOe` is 1 in the address state and during write strobes. It is 0 during read strobes, and after a read it stays 0 until the next address state.
- R13: `ack` is high for exactly one `clk` period after the last byte cycle. `rdData` then holds the bytes that were read, and disabled bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the bus clock rate |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDynWidth | input | 1 | Enables per-cycle width selection from busWidthIn |
| cfgSplitWr | input | 1 | 1: separate low/high write strobes; 0: write plus high-byte enable |
| cfgAdvMode | input | 1 | 1: address-valid level; 0: address latch pulse |
| cfgWaitStates | input | 2 | Number of forced wait states |
| reqValid | input | 1 | Request pending, held until ack |
| reqAddr | input | 15 | Word address (address bits 15:1) |
| reqWData | input | 16 | Write data, odd byte in bits 15:8 |
| reqByteEn | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| reqWrite | input | 1 | 1 write, 0 read |
| reqFetch | input | 1 | Read is an instruction fetch |
| ack | output | 1 | One-period completion pulse |
| rdData | output | 16 | Read result |
| busClk | output | 1 | Bus clock |
| aleOut | output | 1 | Address strobe (pulse or valid level) |
| rdN | output | 1 | Read strobe, active low |
| wrLoN | output | 1 | Write or low-byte write strobe, active low |
| wrHiN | output | 1 | High-byte enable or high-byte write strobe, active low |
| instOut | output | 1 | Instruction fetch indicator |
| adOut | output | 16 | Multiplexed address/data out |
| adOe | output | 1 | Drive enable for adOut |
| adIn | input | 16 | Multiplexed bus input |
| busWidthIn | input | 1 | Width select sampled in the address state |
| readyIn | input | 1 | External ready; low requests wait states |

## Verification
The bench covers every combination of the width-enable bit and the width input, both strobe styles, both address-strobe styles, forced wait counts 0 to 3 and ready-low counts 0 to 2. Each combination runs a read and a write with each of the three byte-enable patterns, and reads alternate between fetch and data. The width and byte-enable pairs separate single 16-bit cycles from split byte cycles and show which lane and address parity each byte uses. Pairing each forced count with each ready count shows whether waits add up or overlap as max(N,K). A modelled memory returns address-dependent bytes, so a wrong lane or a wrong byte order in the read result shows up.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_WAIT = 2'd3
  } busPhase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    busPhase_e phase;       // current bus state
    logic      sub;         // 0: first clock of the state, 1: second clock
    logic      loadReq;     // latch a new request at this edge
    logic      startAddr;   // an address state begins at this edge
    logic      sampleWidth; // take the width input at this edge
    logic      enterStrb;   // address state ends at this edge
    logic      done;        // byte cycle completes at this edge
    logic      nextByte;    // second byte cycle follows
  } busCtl_t;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WAIT_W-1:0] cfgWaitStates,
  input  logic              reqValid,
  input  logic              readyIn,
  input  logic              needSecond,
  output busCtl_t           ctl,
  output logic              ack,
  output logic              busClk
);

  busPhase_e         phase;
  logic              sub;
  logic [WAIT_W-1:0] waitCnt;
  logic              readySmp;
  logic              inData;
  logic              forcedLeft;
  logic              done;

  assign inData     = (phase == PH_STRB) || (phase == PH_WAIT);
  assign forcedLeft = waitCnt < cfgWaitStates;
  assign done       = inData && sub && !forcedLeft && readySmp;
  assign busClk     = ~sub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      sub      <= 1'b0;
      waitCnt  <= '0;
      readySmp <= 1'b1;
      ack      <= 1'b0;
    end else begin
      sub <= ~sub;
      ack <= done && !needSecond;
      if (inData && !sub) readySmp <= readyIn;
      if (sub) begin
        case (phase)
          PH_IDLE: if (reqValid) phase <= PH_ADDR;
          PH_ADDR: begin
            phase   <= PH_STRB;
            waitCnt <= '0;
          end
          default: begin
            if (forcedLeft) begin
              waitCnt <= waitCnt + 1'b1;
              phase   <= PH_WAIT;
            end else if (!readySmp) begin
              phase <= PH_WAIT;
            end else if (needSecond) begin
              phase <= PH_ADDR;
            end else begin
              phase <= PH_IDLE;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.phase       = phase;
    ctl.sub         = sub;
    ctl.loadReq     = (phase == PH_IDLE) && sub && reqValid;
    ctl.nextByte    = done && needSecond;
    ctl.startAddr   = ctl.loadReq || ctl.nextByte;
    ctl.sampleWidth = (phase == PH_ADDR) && !sub;
    ctl.enterStrb   = (phase == PH_ADDR) && sub;
    ctl.done        = done;
  end

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dout <= '0;
    else if (clear) dout <= '0;
    else if (load)  dout <= din;
  end

endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busCtl_t               ctl,
  input  logic                  cfgDynWidth,
  input  logic                  cfgSplitWr,
  input  logic                  cfgAdvMode,
  input  logic                  busWidthIn,
  input  logic [2*BYTE_W-1:1]   reqAddr,
  input  logic [2*BYTE_W-1:0]   reqWData,
  input  logic [1:0]            reqByteEn,
  input  logic                  reqWrite,
  input  logic                  reqFetch,
  input  logic [2*BYTE_W-1:0]   adIn,
  output logic                  needSecond,
  output logic [2*BYTE_W-1:0]   rdData,
  output logic                  aleOut,
  output logic                  rdN,
  output logic                  wrLoN,
  output logic                  wrHiN,
  output logic                  instOut,
  output logic [2*BYTE_W-1:0]   adOut,
  output logic                  adOe
);

  localparam int LANES = 2;
  localparam int BUS_W = LANES * BYTE_W;

  logic [BUS_W-1:1] addrR;
  logic [BUS_W-1:0] wdataR;
  logic [1:0]       beR;
  logic             weR;
  logic             fetchR;
  logic             wideR;
  logic             byteIdx;
  logic             oeR;

  logic             inCycle;
  logic             aleSlot;
  logic             dataPh;
  logic             wrAct;
  logic             curOdd;
  logic [1:0]       curMask;
  logic [BYTE_W-1:0] narrowByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR   <= '0;
      wdataR  <= '0;
      beR     <= 2'b01;
      weR     <= 1'b0;
      fetchR  <= 1'b0;
      wideR   <= 1'b0;
      byteIdx <= 1'b0;
      oeR     <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrR   <= reqAddr;
        wdataR  <= reqWData;
        beR     <= reqByteEn;
        weR     <= reqWrite;
        fetchR  <= reqFetch;
        byteIdx <= 1'b0;
      end else if (ctl.nextByte) begin
        byteIdx <= 1'b1;
      end
      if (ctl.sampleWidth) wideR <= cfgDynWidth & busWidthIn;
      if (ctl.startAddr)                oeR <= 1'b1;
      else if (ctl.enterStrb && !weR)   oeR <= 1'b0;
    end
  end

  // lanes used by the byte cycle in progress
  always_comb begin
    if (byteIdx)     curMask = 2'b10;
    else if (wideR)  curMask = beR;
    else if (beR[0]) curMask = 2'b01;
    else             curMask = 2'b10;
  end

  assign curOdd     = byteIdx | (beR == 2'b10);
  assign needSecond = !wideR && (beR == 2'b11) && !byteIdx;

  // read capture, one register per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] src;
    if (g == 0) begin : gLow
      assign src = adIn[BYTE_W-1:0];
    end else begin : gHigh
      assign src = wideR ? adIn[g*BYTE_W +: BYTE_W] : adIn[BYTE_W-1:0];
    end
    mbus_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk  (clk),
      .rstN (rstN),
      .clear(ctl.loadReq),
      .load (ctl.done && !weR && curMask[g]),
      .din  (src),
      .dout (rdData[g*BYTE_W +: BYTE_W])
    );
  end

  assign inCycle = ctl.phase != PH_IDLE;
  assign aleSlot = (ctl.phase == PH_ADDR) && !ctl.sub;
  assign dataPh  = (ctl.phase == PH_STRB) || (ctl.phase == PH_WAIT);
  assign wrAct   = dataPh && weR;

  assign aleOut  = cfgAdvMode ? !(inCycle && !aleSlot) : aleSlot;
  assign rdN     = !(dataPh && !weR);
  assign wrLoN   = cfgSplitWr ? !(wrAct && curMask[0]) : !wrAct;
  assign wrHiN   = cfgSplitWr ? !(wrAct && curMask[1]) : !(wrAct && wideR && curMask[1]);
  assign instOut = inCycle && fetchR && !weR;
  assign adOe    = oeR;

  assign narrowByte = curOdd ? wdataR[BUS_W-1:BYTE_W] : wdataR[BYTE_W-1:0];

  always_comb begin
    if (wrAct) begin
      if (wideR) adOut = wdataR;
      else       adOut = {addrR[BUS_W-1:BYTE_W], narrowByte};
    end else begin
      adOut = {addrR, curOdd};
    end
  end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgDynWidth,
  input  logic                cfgSplitWr,
  input  logic                cfgAdvMode,
  input  logic [WAIT_W-1:0]   cfgWaitStates,
  input  logic                reqValid,
  input  logic [2*BYTE_W-1:1] reqAddr,
  input  logic [2*BYTE_W-1:0] reqWData,
  input  logic [1:0]          reqByteEn,
  input  logic                reqWrite,
  input  logic                reqFetch,
  output logic                ack,
  output logic [2*BYTE_W-1:0] rdData,
  output logic                busClk,
  output logic                aleOut,
  output logic                rdN,
  output logic                wrLoN,
  output logic                wrHiN,
  output logic                instOut,
  output logic [2*BYTE_W-1:0] adOut,
  output logic                adOe,
  input  logic [2*BYTE_W-1:0] adIn,
  input  logic                busWidthIn,
  input  logic                readyIn
);

  busCtl_t ctl;
  logic    needSecond;

  mbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWaitStates(cfgWaitStates),
    .reqValid     (reqValid),
    .readyIn      (readyIn),
    .needSecond   (needSecond),
    .ctl          (ctl),
    .ack          (ack),
    .busClk       (busClk)
  );

  mbus_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgDynWidth(cfgDynWidth),
    .cfgSplitWr (cfgSplitWr),
    .cfgAdvMode (cfgAdvMode),
    .busWidthIn (busWidthIn),
    .reqAddr    (reqAddr),
    .reqWData   (reqWData),
    .reqByteEn  (reqByteEn),
    .reqWrite   (reqWrite),
    .reqFetch   (reqFetch),
    .adIn       (adIn),
    .needSecond (needSecond),
    .rdData     (rdData),
    .aleOut     (aleOut),
    .rdN        (rdN),
    .wrLoN      (wrLoN),
    .wrHiN      (wrHiN),
    .instOut    (instOut),
    .adOut      (adOut),
    .adOe       (adOe)
  );

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic cfgSplitWr,
  input logic cfgAdvMode,
  input logic ack,
  input logic busClk,
  input logic aleOut,
  input logic rdN,
  input logic wrLoN,
  input logic wrHiN,
  input logic instOut,
  input logic adOe
);

  a_r2_bus_clk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (busClk != $past(busClk)));

  a_r3_latch_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgAdvMode && aleOut) |=> !aleOut);

  a_r8_read_excludes_write: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (wrLoN && wrHiN));

  a_r9_high_enable_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSplitWr && !wrHiN) |-> !wrLoN);

  a_r11_no_fetch_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLoN || !wrHiN) |-> !instOut);

  a_r12_bus_released_in_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  a_r13_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgSplitWr(cfgSplitWr),
  .cfgAdvMode(cfgAdvMode),
  .ack       (ack),
  .busClk    (busClk),
  .aleOut    (aleOut),
  .rdN       (rdN),
  .wrLoN     (wrLoN),
  .wrHiN     (wrHiN),
  .instOut   (instOut),
  .adOe      (adOe)
);

// File: tb/test_mbus_ctrl.sv
module test_mbus_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgDynWidth = 1'b0, cfgSplitWr = 1'b0, cfgAdvMode = 1'b0;
  logic [1:0]  cfgWaitStates = 2'd0;
  logic        reqValid = 1'b0;
  logic [15:1] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [1:0]  reqByteEn = 2'b01;
  logic        reqWrite = 1'b0, reqFetch = 1'b0;
  logic        ack;
  logic [15:0] rdData;
  logic        busClk, aleOut, rdN, wrLoN, wrHiN, instOut, adOe;
  logic [15:0] adOut;
  logic [15:0] adIn;
  logic        busWidthIn = 1'b0;
  logic        readyIn = 1'b1;

  always #4 clk = ~clk;

  mbus_ctrl i_mbus_ctrl (
    .clk(clk), .rstN(rstN), .cfgDynWidth(cfgDynWidth), .cfgSplitWr(cfgSplitWr),
    .cfgAdvMode(cfgAdvMode), .cfgWaitStates(cfgWaitStates), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqByteEn(reqByteEn), .reqWrite(reqWrite),
    .reqFetch(reqFetch), .ack(ack), .rdData(rdData), .busClk(busClk), .aleOut(aleOut),
    .rdN(rdN), .wrLoN(wrLoN), .wrHiN(wrHiN), .instOut(instOut), .adOut(adOut),
    .adOe(adOe), .adIn(adIn), .busWidthIn(busWidthIn), .readyIn(readyIn)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // bus model and monitor state
  logic        wideEff = 1'b0;
  int          kWait = 0;
  logic [15:0] latA = '0;
  logic        prevAle = 1'b0, prevBusClk = 1'b0, prevWr = 1'b0, monStarted = 1'b0;
  int          strobeCnt = 0;
  int          cycN, aleHi, aleLo, rdLo, wlLo, whLo, instHi, ackHi, oeBad, clkBad;
  logic [15:0] cycAddr [2];
  logic [15:0] cycData [2];

  assign adIn = wideEff ? {bv(latA | 16'h1), bv(latA & 16'hFFFE)} : {8'hEE, bv(latA)};

  always @(negedge clk) begin
    if (rstN) begin
      if (monStarted && busClk == prevBusClk) clkBad++;
      monStarted = 1'b1;
      if (prevAle && !aleOut) begin
        latA = adOut;
        if (cycN < 2) cycAddr[cycN] = adOut;
        cycN++;
        if (!adOe) oeBad++;
      end
      if (aleOut) aleHi++; else aleLo++;
      if (!rdN) rdLo++;
      if (!wrLoN) wlLo++;
      if (!wrHiN) whLo++;
      if (!rdN && adOe) oeBad++;
      if ((!wrLoN || !wrHiN) && !adOe) oeBad++;
      if ((!wrLoN || !wrHiN) && !prevWr && cycN > 0 && cycN <= 2) cycData[cycN-1] = adOut;
      if (instOut) instHi++;
      if (ack) ackHi++;
      strobeCnt = (!rdN || !wrLoN || !wrHiN) ? strobeCnt + 1 : 0;
      readyIn   = (strobeCnt >= 2 * kWait);
      prevAle    = aleOut;
      prevBusClk = busClk;
      prevWr     = !wrLoN || !wrHiN;
    end
  end

  function automatic logic [1:0] laneMask(input int c, input logic wide, input logic [1:0] be);
    if (c == 1) return 2'b10;
    if (wide)   return be;
    return be[0] ? 2'b01 : 2'b10;
  endfunction

  task automatic runTxn(input logic dyn, input logic bw, input logic split, input logic adv,
                        input int w, input int k, input logic we, input logic [1:0] be,
                        input logic fetch, input logic [15:0] addr, input logic [15:0] wd);
    int ncyc, lenS, expWl, expWh, waits;
    logic [15:0] expRd;
    @(negedge clk);
    cfgDynWidth = dyn; busWidthIn = bw; cfgSplitWr = split; cfgAdvMode = adv;
    cfgWaitStates = 2'(w); kWait = k; wideEff = dyn & bw;
    @(negedge clk); @(negedge clk);
    @(posedge clk);
    cycN = 0; aleHi = 0; aleLo = 0; rdLo = 0; wlLo = 0; whLo = 0;
    instHi = 0; ackHi = 0; oeBad = 0;
    cycData[0] = '0; cycData[1] = '0; cycAddr[0] = '0; cycAddr[1] = '0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr[15:1]; reqWData = wd; reqByteEn = be;
    reqWrite = we; reqFetch = fetch;
    do @(negedge clk); while (!ack);
    reqValid = 1'b0;
    repeat (4) @(posedge clk);

    ncyc  = (!wideEff && be == 2'b11) ? 2 : 1;
    waits = (w > k) ? w : k;
    lenS  = 2 * (1 + waits);
    chk(cycN == ncyc, "R4 R5 byte cycle count", cycN, ncyc);
    chk(cycAddr[0] == {addr[15:1], be == 2'b10}, "R5 first address", cycAddr[0], {addr[15:1], be == 2'b10});
    if (ncyc == 2)
      chk(cycAddr[1] == {addr[15:1], 1'b1}, "R5 second address odd", cycAddr[1], {addr[15:1], 1'b1});
    if (adv) chk(aleLo == ncyc * (1 + lenS), "R10 valid level low time", aleLo, ncyc * (1 + lenS));
    else     chk(aleHi == ncyc, "R3 latch pulse one clock per cycle", aleHi, ncyc);
    chk(ackHi == 1, "R13 ack single pulse", ackHi, 1);
    chk(oeBad == 0, "R12 drive enable during strobes", oeBad, 0);
    chk(adOe == we, "R12 drive enable after transfer", adOe, we);
    chk(instHi == ((fetch && !we) ? ncyc * (2 + lenS) : 0), "R11 fetch indicator span",
        instHi, (fetch && !we) ? ncyc * (2 + lenS) : 0);
    if (!we) begin
      chk(rdLo == ncyc * lenS, (waits == 0) ? "R3 read strobe length" : "R6 R7 read strobe length",
          rdLo, ncyc * lenS);
      chk(wlLo == 0 && whLo == 0, "R8 no write strobe on read", wlLo + whLo, 0);
      expRd = {be[1] ? bv({addr[15:1], 1'b1}) : 8'h00, be[0] ? bv({addr[15:1], 1'b0}) : 8'h00};
      chk(rdData == expRd, "R13 R4 read data", rdData, expRd);
    end else begin
      expWl = 0; expWh = 0;
      for (int c = 0; c < ncyc; c++) begin
        logic [1:0] m;
        logic       odd;
        m = laneMask(c, wideEff, be);
        if (split) begin
          if (m[0]) expWl += lenS;
          if (m[1]) expWh += lenS;
        end else begin
          expWl += lenS;
          if (wideEff && m[1]) expWh += lenS;
        end
        odd = (c == 1) || (be == 2'b10);
        if (wideEff)
          chk(cycData[c] == wd, "R4 wide write data", cycData[c], wd);
        else
          chk(cycData[c][7:0] == (odd ? wd[15:8] : wd[7:0]), "R4 R5 narrow write data",
              cycData[c][7:0], odd ? wd[15:8] : wd[7:0]);
      end
      chk(rdLo == 0, "R8 no read strobe on write", rdLo, 0);
      chk(wlLo == expWl, split ? "R8 low write strobe" : "R9 write strobe", wlLo, expWl);
      chk(whLo == expWh, split ? "R8 high write strobe" : "R9 high byte enable", whLo, expWh);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdN && wrLoN && wrHiN, "R1 strobes idle in reset", {rdN, wrLoN, wrHiN}, 3'b111);
    chk(!ack && !instOut && !adOe && !aleOut, "R1 outputs low in reset",
        {ack, instOut, adOe, aleOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdN && wrLoN && wrHiN && !adOe && !ack, "R1 idle after reset",
        {rdN, wrLoN, wrHiN, adOe, ack}, 5'b11100);
    begin
      int idx;
      idx = 0;
      for (int dyn = 0; dyn < 2; dyn++)
        for (int bw = 0; bw < 2; bw++)
          for (int sp = 0; sp < 2; sp++)
            for (int adv = 0; adv < 2; adv++)
              for (int w = 0; w < 4; w++)
                for (int k = 0; k < 3; k++)
                  for (int we = 0; we < 2; we++)
                    for (int be = 1; be < 4; be++) begin
                      logic [15:0] a, d;
                      a = 16'(idx * 16'h1357) ^ 16'hA5C3;
                      d = 16'(idx * 16'h2B1D) ^ 16'h6E49;
                      runTxn(dyn[0], bw[0], sp[0], adv[0], w, k, we[0], be[1:0],
                             (we == 0) && idx[0], a, d);
                      idx++;
                    end
    end
    chk(clkBad == 0, "R2 bus clock toggles every clock", clkBad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule